// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Latch

This block guards the switched supply rails of a hot-pluggable card. For each rail it receives one digital overcurrent flag, produced by an external comparator that watches the drop across a sense resistor. A flag counts as real only once it has stayed high for a number of consecutive clock cycles. That count is short while the rails are still ramping and longer once they have settled. A qualified overcurrent on any rail turns off every gate enable and pulls the active-low fault flag low, in the same clock edge.

The fault is latched. The host clears it by driving the power-enable input low and then high again. On the edge that sees power-enable return high, the fault flag releases and the gate enables switch back on together. A synchronous reset also clears the latch and leaves the gates off.

The controller has four states. `ST_OFF`: gates off, no fault. `ST_ON`: gates on, rails monitored. `ST_TRIP`: fault latched while power-enable is still high. `ST_REARM`: fault latched and power-enable has been seen low.

The transitions are:
- `ST_OFF`→`ST_ON` when power-enable is high.
- `ST_ON`→`ST_OFF` when power-enable is low.
- `ST_ON`→`ST_TRIP` on any qualified trip.
- `ST_TRIP`→`ST_REARM` when power-enable is low.
- `ST_REARM`→`ST_ON` when power-enable is high.

A trip takes priority over power-enable falling in `ST_ON`.

Top module: `oc_breaker`

## Requirements
- R1: After synchronous reset, all gate enables are 0 and the fault flag is 1 (deasserted).
- R2: With no fault latched, power-enable sampled high turns all gate enables on at the next clock edge, and power-enable sampled low turns them off at the next clock edge.
- R3: While the ramp input is 1, an overcurrent flag must be sampled high on RAMP_CYCLES consecutive edges to trip; the trip shows on the outputs right after the last of those edges, and a shorter run causes no trip.
- R4: While the ramp input is 0, an overcurrent flag must be sampled high on RUN_CYCLES consecutive edges to trip; a shorter run causes no trip.
- R5: An overcurrent flag that drops before its window completes restarts that rail's count from zero.
- R6: Any rail's flag can trip the breaker. All rails share one fault state, and every gate enable goes off together.
- R7: On a trip, the fault flag goes to 0 and all gate enables go to 0 on the same clock edge.
- R8: While a fault is latched and power-enable stays high, the fault and the gate-off state hold, whatever the overcurrent flags do.
- R9: A latched fault clears only after power-enable is seen low and then high. Power-enable low alone keeps the fault flag at 0. The fault flag returns to 1 on the same edge that turns the gate enables back on.
- R10: Synchronous reset clears a latched fault (flag 1, gates 0). A later power-enable high turns the gates on.
- R11: While the gates are off, overcurrent flags are ignored. They neither trip nor pre-load a count, so after power-on a full window is still needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_en_i | input | 1 | Host power enable; a low-then-high cycle clears a fault |
| ramp_i | input | 1 | 1 while rails are ramping (short window), 0 in steady operation |
| oc_i | input | N_RAILS | Per-rail overcurrent comparator flags, 1 = over limit |
| gate_en_o | output | N_RAILS | Per-rail gate enables for the pass transistors |
| fault_n_o | output | 1 | Active-low latched overcurrent fault |

## Verification
The bench builds the block with RAMP_CYCLES = 3 and RUN_CYCLES = 7 instead of the microsecond-scale defaults. Short windows make it cheap to sweep every run length from 1 to one past each window, on both rails and in both phases. They also bring the restart-on-drop case, the ignore-while-off case and the full clear sequence within a few dozen cycles. Every expected outcome follows from comparing the run length with the window chosen by the ramp input.

// File: rtl/oc_breaker_pkg.sv
package oc_breaker_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_TRIP  = 2'd2,
        ST_REARM = 2'd3
    } brk_state_t;
endpackage

// File: rtl/oc_qualifier.sv
module oc_qualifier #(
    parameter int RAMP_CYCLES = 200,
    parameter int RUN_CYCLES  = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic ramp_i,
    input  logic oc_i,
    output logic trip_o
);
    localparam int CW = $clog2(RUN_CYCLES + 1);
    localparam logic [CW-1:0] RAMP_LAST = CW'(RAMP_CYCLES - 1);
    localparam logic [CW-1:0] RUN_LAST  = CW'(RUN_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last   = ramp_i ? RAMP_LAST : RUN_LAST;
        trip_o = arm_i && oc_i && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !oc_i) begin
            cnt <= '0;
        end else if (cnt < last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: a dropped flag leaves the count at zero
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        !oc_i |=> (cnt == '0));

    // R11: counting happens only while armed
    a_r11_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> (cnt == '0));

    // R4: count never runs past the longer window
    a_r4_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= RUN_LAST);
endmodule

// File: rtl/oc_breaker_fsm.sv
module oc_breaker_fsm
    import oc_breaker_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_en_i,
    input  logic trip_i,
    output logic gates_on_o,
    output logic fault_n_o
);
    brk_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (pwr_en_i)  state_nx = ST_ON;
            ST_ON: begin
                if (trip_i)          state_nx = ST_TRIP;
                else if (!pwr_en_i)  state_nx = ST_OFF;
            end
            ST_TRIP:  if (!pwr_en_i) state_nx = ST_REARM;
            ST_REARM: if (pwr_en_i)  state_nx = ST_ON;
            default:                 state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    always_comb begin
        gates_on_o = (state == ST_ON);
        fault_n_o  = !((state == ST_TRIP) || (state == ST_REARM));
    end

    // R8: latched fault holds while enable stays high
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRIP && pwr_en_i) |=> (state == ST_TRIP));

    // R6: a trip seen while on always latches
    a_r6_latch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && trip_i) |=> !fault_n_o);
endmodule

// File: rtl/oc_breaker.sv
module oc_breaker #(
    parameter int N_RAILS     = 2,
    parameter int RAMP_CYCLES = 200,
    parameter int RUN_CYCLES  = 800
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_en_i,
    input  logic               ramp_i,
    input  logic [N_RAILS-1:0] oc_i,
    output logic [N_RAILS-1:0] gate_en_o,
    output logic               fault_n_o
);
    logic [N_RAILS-1:0] trip;
    logic               gates_on;

    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        oc_qualifier #(
            .RAMP_CYCLES(RAMP_CYCLES),
            .RUN_CYCLES (RUN_CYCLES)
        ) u_qual (
            .clk   (clk),
            .rst   (rst),
            .arm_i (gates_on),
            .ramp_i(ramp_i),
            .oc_i  (oc_i[g]),
            .trip_o(trip[g])
        );
    end

    oc_breaker_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pwr_en_i  (pwr_en_i),
        .trip_i    (|trip),
        .gates_on_o(gates_on),
        .fault_n_o (fault_n_o)
    );

    assign gate_en_o = {N_RAILS{gates_on}};

    // R7: no gate is ever on while the fault is asserted
    a_r7_fault_gate: assert property (@(posedge clk) disable iff (rst)
        !fault_n_o |-> (gate_en_o == '0));

    // R9: fault release coincides with gates turning on
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_n_o) && !$past(rst)) |-> (gate_en_o == {N_RAILS{1'b1}}));

    // R9: clearing needs power enable to have been low before
    a_r9_needs_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_n_o) && !$past(rst)) |-> $past(pwr_en_i, 2) == 1'b0);
endmodule

// File: tb/oc_breaker_test.sv
module oc_breaker_test;
    localparam int NR   = 2;
    localparam int RAMP = 3;
    localparam int RUN  = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_en = 1'b0;
    logic          ramp = 1'b0;
    logic [NR-1:0] oc = '0;
    logic [NR-1:0] gate_en;
    logic          fault_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    oc_breaker #(.N_RAILS(NR), .RAMP_CYCLES(RAMP), .RUN_CYCLES(RUN)) uut (
        .clk(clk), .rst(rst), .pwr_en_i(pwr_en), .ramp_i(ramp),
        .oc_i(oc), .gate_en_o(gate_en), .fault_n_o(fault_n)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(string req, logic [NR-1:0] g_exp, logic f_exp);
        n_tests++;
        if (gate_en !== g_exp || fault_n !== f_exp) begin
            n_fail++;
            $display("FAIL %s: gate_en=%b fault_n=%b expected gate_en=%b fault_n=%b",
                     req, gate_en, fault_n, g_exp, f_exp);
        end
    endtask

    // clears a latched fault and checks the release sequence
    task automatic clear_fault();
        pwr_en = 1'b0; tick();
        check("R9 low only", '0, 1'b0);
        tick(2);
        check("R9 low held", '0, 1'b0);
        pwr_en = 1'b1; tick();
        check("R9 release", '1, 1'b1);
    endtask

    initial begin
        tick(2);
        check("R1 reset", '0, 1'b1);
        rst = 1'b0;
        tick();
        check("R1 idle", '0, 1'b1);
        pwr_en = 1'b1; tick();
        check("R2 on", '1, 1'b1);
        pwr_en = 1'b0; tick();
        check("R2 off", '0, 1'b1);
        pwr_en = 1'b1; tick();
        check("R2 on again", '1, 1'b1);

        // R3 / R4 / R6 / R7 sweep: every run length, both rails, both phases
        for (int ph = 0; ph < 2; ph++) begin
            for (int r = 0; r < NR; r++) begin
                for (int len = 1; len <= RUN + 1; len++) begin
                    automatic int lim = (ph == 1) ? RAMP : RUN;
                    automatic bit hit;
                    if (ph == 1 && len > RAMP + 1) continue;
                    ramp = (ph == 1);
                    oc[r] = 1'b1;
                    tick(len);
                    oc = '0;
                    hit = (len >= lim);
                    if (ph == 1) check("R3 ramp window", hit ? '0 : '1, !hit);
                    else         check("R4 run window", hit ? '0 : '1, !hit);
                    tick();
                    if (hit) begin
                        check("R7 latched", '0, 1'b0);
                        clear_fault();
                    end else begin
                        check("R6 no trip", '1, 1'b1);
                    end
                end
            end
        end

        // R5: drop before expiry restarts the count
        ramp = 1'b0;
        oc[1] = 1'b1; tick(RUN - 1);
        oc = '0; tick();
        oc[1] = 1'b1; tick(RUN - 1);
        check("R5 restarted", '1, 1'b1);
        tick();
        check("R5 full window", '0, 1'b0);
        oc = '0;

        // R8: latched fault holds under flag activity with enable high
        for (int i = 0; i < 12; i++) begin
            oc = NR'(i);
            tick();
            check("R8 hold", '0, 1'b0);
        end
        oc = '0;
        clear_fault();

        // R11: flags ignored while gates are off
        pwr_en = 1'b0; tick();
        oc = '1; tick(RUN + 3);
        check("R11 ignored off", '0, 1'b1);
        pwr_en = 1'b1; tick();
        check("R11 power on", '1, 1'b1);
        tick(RUN - 1);
        check("R11 no preload", '1, 1'b1);
        tick();
        check("R11 full window", '0, 1'b0);
        oc = '0;

        // R10: reset clears the latch
        rst = 1'b1; tick();
        check("R10 reset clears", '0, 1'b1);
        rst = 1'b0; tick();
        check("R10 on after reset", '1, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule